// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block supplies the interrupt and status logic that sits beside a pair of 256-entry data FIFOs in a serial port controller. It does not hold any FIFO storage. It watches the current occupancy of both FIFOs, the strobes that write into and read from the receive FIFO, and a busy indication from the serial engine. From these it produces four interrupt sources: a transmit request, a receive request, a receive overflow and a receive timeout. It also drives one combined interrupt line.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge and reads are combinational. Through this port software sets a 3-bit level code for each direction, enables or blocks each source, clears the two sticky error events and reads back the FIFO condition flags. The transmit and receive requests have no memory and always reflect the present occupancy. Only overflow and timeout latch. The block also qualifies the receive write strobe, so that a word arriving at a full FIFO never reaches the storage.

Top module: `fifo_thresh_irq`

## Requirements
- R1: After reset the mask register (address 1) reads 0xF, the threshold register (address 0), the timeout limit (address 6) and the masked status (address 3) read 0, raw status bits 0 and 1 are 0, and `irq` is low.
- R2: The threshold register holds the transmit code in bits 5:3 and the receive code in bits 11:9. Codes 0,1,2,3,4,5,6,7 select levels 1,4,8,16,32,64,128,256.
- R3: Raw status bit 3 (transmit request) is 1 exactly when `tx_level` is less than or equal to the selected transmit level.
- R4: Raw status bit 2 (receive request) is 1 exactly when `rx_level` is greater than or equal to the selected receive level.
- R5: When `rx_push` is high while `rx_level` is 256, `rx_wr_en` stays low and raw status bit 0 (overflow) is set at the next edge. In all other cases `rx_wr_en` follows `rx_push`.
- R6: Raw status bit 1 (timeout) is set at the edge that completes N consecutive cycles in which `rx_level` is nonzero and neither `rx_push` nor `rx_pop` is high. N is the value at address 6. A push or a pop restarts the count. Each idle stretch sets the flag once. N = 0 disables the timeout.
- R7: Writing a 1 to bit 0 or bit 1 of the clear register (address 4) clears the overflow or timeout flag. A set event in the same cycle takes priority. Writes to bits 2 and 3 have no effect on the request bits.
- R8: A mask bit of 1 blocks its source. Masked status (address 3) equals the raw status (address 2) ANDed with the inverted mask, and `irq` is high when any masked bit is 1.
- R9: The FIFO status word (address 5) reports TX empty at bit 0, TX not full at bit 1, RX not empty at bit 2, RX full at bit 3 and `eng_busy` at bit 4. Upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_level | input | 9 | Current transmit FIFO occupancy, 0 to 256 |
| rx_level | input | 9 | Current receive FIFO occupancy, 0 to 256 |
| rx_push | input | 1 | A received word is offered to the receive FIFO |
| rx_pop | input | 1 | A word is read out of the receive FIFO |
| eng_busy | input | 1 | Serial engine busy indication |
| rx_wr_en | output | 1 | Qualified receive FIFO write strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt output |

## Verification
The assertions run on every cycle. They check that a word offered at a full receive FIFO is always blocked and always latches the overflow flag, that a latched overflow holds until a clear write reaches it, that a timeout only rises after a cycle with data in the receive FIFO, that the request bits agree with the empty-FIFO cases, and that `irq` stays low while every source is masked. Some behaviours can only be shown by the directed scenarios: the exact edge on which the timeout fires for a given limit, the single firing per idle stretch, the restart after a pop, the full sweep of the eight level codes at their boundaries, and a set winning over a clear in the same cycle.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_THR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_RAW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MST  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FST  = 3'd5;
  localparam logic [ADDR_W-1:0] A_TOL  = 3'd6;

  localparam int unsigned NSRC = 4;

  // Level selected by a 3-bit threshold code: 1, then powers of two from 4.
  function automatic logic [31:0] code_level(input logic [2:0] code);
    if (code == 3'd0) code_level = 32'd1;
    else              code_level = 32'd2 << code;
  endfunction
endpackage

// File: rtl/fti_rst_sync.sv
module fti_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fti_level_req.sv
module fti_level_req #(
  parameter int unsigned LVL_W = 9,
  parameter bit          IS_TX = 1'b1
) (
  input  logic [LVL_W-1:0] level,
  input  logic [2:0]       code,
  output logic             req
);
  logic [31:0] thr;
  logic [31:0] lvl_ext;

  assign thr     = fti_pkg::code_level(code);
  assign lvl_ext = {{(32-LVL_W){1'b0}}, level};

  generate
    if (IS_TX) begin : g_tx
      assign req = (lvl_ext <= thr);
    end else begin : g_rx
      assign req = (lvl_ext >= thr);
    end
  endgenerate
endmodule

// File: rtl/fti_rx_events.sv
module fti_rx_events #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LVL_W = 9,
  parameter int unsigned TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             clr_of,
  input  logic             clr_to,
  output logic             rx_full,
  output logic             rx_wr_en,
  output logic             of_flag,
  output logic             to_flag
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            of_q, of_d, to_q, to_d;
  logic            idle, of_evt, to_evt;

  assign rx_full  = (rx_level == FULL_LVL);
  assign rx_wr_en = rx_push & ~rx_full;
  assign of_evt   = rx_push & rx_full;
  assign idle     = (rx_level != '0) & ~rx_push & ~rx_pop;
  assign to_evt   = idle & (to_limit != '0) & (cnt_q == to_limit - 1'b1);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!idle) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != to_limit) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
    of_d = of_evt | (of_q & ~clr_of);
    to_d = to_evt | (to_q & ~clr_to);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      of_q  <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      of_q <= of_d;
      to_q <= to_d;
    end
  end

  assign of_flag = of_q;
  assign to_flag = to_q;
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LVL_W-1:0]           tx_level,
  input  logic [LVL_W-1:0]           rx_level,
  input  logic                       rx_push,
  input  logic                       rx_pop,
  input  logic                       eng_busy,
  output logic                       rx_wr_en,
  input  logic                       reg_wr,
  input  logic [fti_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       irq
);
  import fti_pkg::*;

  localparam int unsigned TO_W = DATA_W;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic             rst_sync_n;
  logic [2:0]       thr_tx_q, thr_rx_q, thr_tx_d, thr_rx_d;
  logic [NSRC-1:0]  mask_q, mask_d;
  logic [TO_W-1:0]  tol_q, tol_d;
  logic             wr_thr, wr_mask, wr_tol, clr_of, clr_to;
  logic             tx_req, rx_req, rx_full, of_flag, to_flag;
  logic [NSRC-1:0]  raw_st, msk_st;
  logic [4:0]       fstat;

  fti_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  fti_level_req #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_req (
    .level(tx_level), .code(thr_tx_q), .req(tx_req));
  fti_level_req #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_req (
    .level(rx_level), .code(thr_rx_q), .req(rx_req));

  fti_rx_events #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TO_W(TO_W)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .rx_level(rx_level), .rx_push(rx_push),
    .rx_pop(rx_pop), .to_limit(tol_q), .clr_of(clr_of), .clr_to(clr_to),
    .rx_full(rx_full), .rx_wr_en(rx_wr_en), .of_flag(of_flag), .to_flag(to_flag));

  assign wr_thr  = reg_wr & (reg_addr == A_THR);
  assign wr_mask = reg_wr & (reg_addr == A_MASK);
  assign wr_tol  = reg_wr & (reg_addr == A_TOL);
  assign clr_of  = reg_wr & (reg_addr == A_CLR) & reg_wdata[0];
  assign clr_to  = reg_wr & (reg_addr == A_CLR) & reg_wdata[1];

  always_comb begin
    thr_tx_d = reg_wdata[5:3];
    thr_rx_d = reg_wdata[11:9];
    mask_d   = reg_wdata[NSRC-1:0];
    tol_d    = reg_wdata[TO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      thr_tx_q <= '0;
      thr_rx_q <= '0;
      mask_q   <= '1;
      tol_q    <= '0;
    end else begin
      if (wr_thr) begin
        thr_tx_q <= thr_tx_d;
        thr_rx_q <= thr_rx_d;
      end
      if (wr_mask) mask_q <= mask_d;
      if (wr_tol)  tol_q  <= tol_d;
    end
  end

  assign raw_st = {tx_req, rx_req, to_flag, of_flag};
  assign msk_st = raw_st & ~mask_q;
  assign irq    = |msk_st;
  assign fstat  = {eng_busy, rx_full, (rx_level != '0),
                   (tx_level != FULL_LVL), (tx_level == '0)};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_THR: begin
        reg_rdata[5:3]  = thr_tx_q;
        reg_rdata[11:9] = thr_rx_q;
      end
      A_MASK:  reg_rdata[NSRC-1:0] = mask_q;
      A_RAW:   reg_rdata[NSRC-1:0] = raw_st;
      A_MST:   reg_rdata[NSRC-1:0] = msk_st;
      A_FST:   reg_rdata[4:0]      = fstat;
      A_TOL:   reg_rdata[TO_W-1:0] = tol_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LVL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_push,
  input logic             rx_wr_en,
  input logic             clr_wr,
  input logic             clr_bit0,
  input logic [3:0]       raw,
  input logic [3:0]       mask,
  input logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // R5: a word offered at a full FIFO never reaches the storage
  a_r5_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == FULL_LVL) |-> !rx_wr_en);

  // R5: the same event latches the overflow flag
  a_r5_overflow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == FULL_LVL) |=> raw[0]);

  // R7: overflow holds until a clear write targets it
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] && !(clr_wr && clr_bit0)) |=> raw[0]);

  // R6: a timeout only rises after a cycle with receive data present
  a_r6_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[1]) |-> $past(rx_level != '0));

  // R3: an empty transmit FIFO always meets any transmit level
  a_r3_tx_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> raw[3]);

  // R4: an empty receive FIFO never meets any receive level
  a_r4_rx_empty_noreq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !raw[2]);

  // R8: all sources blocked keeps the interrupt low
  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'hF) |-> !irq);
endmodule

bind fifo_thresh_irq fti_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_level(tx_level), .rx_level(rx_level),
  .rx_push(rx_push), .rx_wr_en(rx_wr_en),
  .clr_wr(reg_wr && (reg_addr == fti_pkg::A_CLR)), .clr_bit0(reg_wdata[0]),
  .raw(raw_st), .mask(mask_q), .irq(irq));

// File: tb/fifo_thresh_irq_tb_top.sv
module fifo_thresh_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  tx_level = '0, rx_level = '0;
  logic        rx_push = 1'b0, rx_pop = 1'b0, eng_busy = 1'b0;
  logic        rx_wr_en, irq;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] THR = 0, MSK = 1, RAW = 2, MST = 3, CLR = 4, FST = 5, TOL = 6;

  always #5 clk = ~clk;

  fifo_thresh_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .rx_pop(rx_pop), .eng_busy(eng_busy), .rx_wr_en(rx_wr_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int exp_lvl(input int c);
    case (c)
      0: return 1;   1: return 4;   2: return 8;   3: return 16;
      4: return 32;  5: return 64;  6: return 128; default: return 256;
    endcase
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    rd(MSK, d); chk("R1 mask", d, 16'hF);
    rd(THR, d); chk("R1 thr", d, 16'h0);
    rd(TOL, d); chk("R1 tol", d, 16'h0);
    rd(MST, d); chk("R1 mstat", d, 16'h0);
    rd(RAW, d); chk("R1 raw sticky", d & 16'h3, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_thresholds;
    logic [15:0] d;
    for (int c = 0; c < 8; c++) begin
      int l = exp_lvl(c);
      wr(THR, 16'((c << 3) | (c << 9)));
      rd(THR, d); chk("R2 code readback", d, 16'((c << 3) | (c << 9)));
      rx_level = 9'(l - 1); rd(RAW, d); chk("R4 below level", (d >> 2) & 1, 0);
      rx_level = 9'(l);     rd(RAW, d); chk("R4 at level", (d >> 2) & 1, 1);
      tx_level = 9'(l);     rd(RAW, d); chk("R3 at level", (d >> 3) & 1, 1);
      if (l < 256) begin
        tx_level = 9'(l + 1); rd(RAW, d); chk("R3 above level", (d >> 3) & 1, 0);
      end
    end
    tx_level = 0; rx_level = 0;
    wr(THR, 16'h0);
  endtask

  task automatic t_overflow;
    logic [15:0] d;
    rx_level = 9'd256; rx_push = 1'b1;
    #1 chk("R5 full push blocked", {15'b0, rx_wr_en}, 16'h0);
    step(1); rx_push = 1'b0;
    rd(RAW, d); chk("R5 overflow set", d & 1, 1);
    rx_level = 9'd10; rx_push = 1'b1;
    #1 chk("R5 push passes", {15'b0, rx_wr_en}, 16'h1);
    step(1); rx_push = 1'b0;
    wr(CLR, 16'h1);
    rd(RAW, d); chk("R7 overflow cleared", d & 1, 0);
    rx_level = 9'd256; rx_push = 1'b1;
    wr(CLR, 16'h1);
    rx_push = 1'b0;
    rd(RAW, d); chk("R7 set beats clear", d & 1, 1);
    wr(CLR, 16'h1);
    rd(RAW, d); chk("R7 cleared again", d & 1, 0);
    rx_level = 0;
  endtask

  task automatic t_timeout;
    logic [15:0] d;
    wr(TOL, 16'd5);
    rx_level = 9'd3;
    step(4); rd(RAW, d); chk("R6 not yet", (d >> 1) & 1, 0);
    step(1); rd(RAW, d); chk("R6 fires at limit", (d >> 1) & 1, 1);
    wr(CLR, 16'h2);
    rd(RAW, d); chk("R7 timeout cleared", (d >> 1) & 1, 0);
    step(8); rd(RAW, d); chk("R6 once per idle stretch", (d >> 1) & 1, 0);
    rx_pop = 1'b1; step(1); rx_pop = 1'b0;
    step(4); rd(RAW, d); chk("R6 restart after pop", (d >> 1) & 1, 0);
    step(1); rd(RAW, d); chk("R6 fires after restart", (d >> 1) & 1, 1);
    wr(CLR, 16'h2);
    wr(TOL, 16'd0);
    step(20); rd(RAW, d); chk("R6 limit zero disables", (d >> 1) & 1, 0);
    rx_level = 0;
  endtask

  task automatic t_clear_ignored;
    logic [15:0] d;
    rx_level = 9'd256; tx_level = 0;
    wr(CLR, 16'hC);
    rd(RAW, d); chk("R7 request bits unaffected", d, 16'hC);
    rx_level = 0;
  endtask

  task automatic t_mask_irq;
    logic [15:0] d;
    chk("R8 masked quiet", {15'b0, irq}, 16'h0);
    wr(MSK, 16'h7);
    rd(MST, d); chk("R8 tx unmasked mstat", d, 16'h8);
    chk("R8 irq high", {15'b0, irq}, 16'h1);
    wr(THR, 16'h20);
    tx_level = 9'd100;
    rd(MST, d); chk("R8 mstat after level", d, 16'h0);
    chk("R8 irq low", {15'b0, irq}, 16'h0);
    wr(MSK, 16'hF); wr(THR, 16'h0); tx_level = 0;
  endtask

  task automatic t_status;
    logic [15:0] d;
    tx_level = 0; rx_level = 0; eng_busy = 0;
    rd(FST, d); chk("R9 idle", d, 16'h03);
    tx_level = 9'd256; rx_level = 9'd256; eng_busy = 1;
    rd(FST, d); chk("R9 full busy", d, 16'h1C);
    tx_level = 9'd5; rx_level = 9'd1; eng_busy = 0;
    rd(FST, d); chk("R9 partial", d, 16'h06);
    tx_level = 0; rx_level = 0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_thresholds();
    t_overflow();
    t_timeout();
    t_clear_ignored();
    t_mask_irq();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule